// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-bit Words

This block is a two-wire serial slave that exposes a bank of 16-bit registers through an 8-bit register pointer. The serial clock and data lines are oversampled on a faster system clock. The data line is driven open-drain style: the block only ever pulls it low, by raising `sda_oe`. Two strap pins pick one of four device addresses. Register traffic leaves the block on a plain read port and a plain write port, and the register storage sits outside the block.

Every register word crosses the bus as two bytes, most significant byte first. The pointer steps by one after each complete word, in both directions. A master that can only move single bytes still reaches full words through a low-byte port register at pointer 0xF0. A lone byte written to an ordinary register is held back. The next byte written to 0xF0 supplies the low half and commits the whole word. Reading 0xF0 returns the low half of the word most recently fetched.

Top module: `twowire_reg_slave`

## Requirements
- R1: The device address is 0x90 with bit 3 set by `adr0` and bit 5 set by `adr1`. The address bit 0 selects write (0) or read (1). A matching address is acknowledged by holding SDA low during the ninth clock.
- R2: A non-matching device address is not acknowledged. The block then leaves SDA released and performs no register access until the next start condition.
- R3: In a write, the register-pointer byte and every data byte are acknowledged. Two data bytes produce exactly one `reg_we` pulse, lasting one cycle, at the pointer, with data {first byte, second byte}.
- R4: After each complete 16-bit word, the pointer increments by one, for writes and for reads alike.
- R5: A read uses a write phase to set the pointer, then a repeated start with the read address. Data is shifted out MSB first. An acknowledge from the master continues the read. A no-acknowledge ends it, and the block releases SDA and ignores the following clocks.
- R6: A start or stop ends a write. A lone first byte of a word causes no register write.
- R7: A byte written to pointer 0xF0 commits {staged first byte, this byte} to the register that received the staged byte. Pointer 0xF0 itself is never written.
- R8: A byte read from pointer 0xF0 returns the low byte of the last word fetched, including a word of which only the upper byte was read.
- R9: Out of reset `sda_oe`, `reg_we` and `reg_re` are low. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the data line is pulled low |
| adr0 | input | 1 | Strap pin for device address bit 3 |
| adr1 | input | 1 | Strap pin for device address bit 5 |
| reg_re | output | 1 | Read strobe for a word fetch |
| reg_raddr | output | 8 | Register read address |
| reg_rdata | input | 16 | Register read data, combinational from `reg_raddr` |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_waddr | output | 8 | Register write address |
| reg_wdata | output | 16 | Register write data |

## Verification
A table of word patterns (mixed, all ones, all zeros, alternating) is written and read back at scattered pointers. This separates correct byte order and bit order from swapped halves or stuck bits. Multi-word bursts distinguish auto-increment per word from increment per byte. Each strap-pin combination is addressed, along with a wrong address, so that a misplaced strap bit or a missing mismatch check shows up. Lone bytes, writes cut short by a start, and reads of the low-byte port separate correct staging from premature writes and from returning the wrong half.

// File: rtl/tw_pkg.sv
// Shared constants and types for the two-wire register slave.
package tw_pkg;
    localparam int TW_BW = 8;                   // bus byte width
    localparam int TW_AW = 8;                   // register pointer width
    localparam int TW_DW = 2 * TW_BW;           // register word width
    localparam logic [7:0] TW_BASE_ADDR = 8'h90; // device address, straps low
    localparam logic [TW_AW-1:0] TW_LOW_PORT = 8'hF0; // low-byte port

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ACK_A, S_REG, S_ACK_R,
        S_WDATA, S_ACK_W, S_RDATA, S_RACK
    } tw_state_t;
endpackage

// File: rtl/tw_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// clock edges and start/stop events from the synchronized lines.
// Assumes both lines are stable for several system clocks per SCL phase.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p;

    // Synchronizer chains plus one history flop per line; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s    = scl_q[STAGES-1];
    assign sda_s    = sda_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_word_access.sv
// Turns byte events from the bit engine into 16-bit register accesses.
// Holds the pointer, the word phase, the staged first byte and the low
// byte of the last fetched word. Assumes reg_rdata is valid in the same
// cycle as reg_raddr.
module tw_word_access
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             set_ptr,
    input  logic             wr_byte,
    input  logic             rd_byte,
    input  logic [TW_BW-1:0] rx_byte,
    output logic [TW_BW-1:0] tx_byte,
    input  logic [TW_DW-1:0] reg_rdata,
    output logic             reg_re,
    output logic [TW_AW-1:0] reg_raddr,
    output logic             reg_we,
    output logic [TW_AW-1:0] reg_waddr,
    output logic [TW_DW-1:0] reg_wdata
);
    logic [TW_AW-1:0] ptr, stage_addr;
    logic [TW_BW-1:0] stage_msb, lo_hold, last_lo;
    logic             phase;
    logic             at_port;

    assign at_port   = (ptr == TW_LOW_PORT);
    assign reg_raddr = ptr;
    assign reg_re    = rd_byte & ~at_port & ~phase;

    // Byte to transmit: port byte, held low half, or upper half of a fresh fetch.
    always_comb begin
        if (at_port)    tx_byte = last_lo;
        else if (phase) tx_byte = lo_hold;
        else            tx_byte = reg_rdata[TW_DW-1:TW_BW];
    end

    // Pointer, staging and write-strobe bookkeeping per received or sent byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            stage_addr <= '0;
            stage_msb  <= '0;
            lo_hold    <= '0;
            last_lo    <= '0;
            phase      <= 1'b0;
            reg_we     <= 1'b0;
            reg_waddr  <= '0;
            reg_wdata  <= '0;
        end else begin
            reg_we <= 1'b0;
            if (frame_start) begin
                phase <= 1'b0;
            end else if (set_ptr) begin
                ptr   <= rx_byte;
                phase <= 1'b0;
            end else if (wr_byte) begin
                if (at_port) begin
                    reg_we    <= 1'b1;
                    reg_waddr <= stage_addr;
                    reg_wdata <= {stage_msb, rx_byte};
                end else if (!phase) begin
                    stage_msb  <= rx_byte;
                    stage_addr <= ptr;
                    phase      <= 1'b1;
                end else begin
                    reg_we    <= 1'b1;
                    reg_waddr <= ptr;
                    reg_wdata <= {stage_msb, rx_byte};
                    ptr       <= ptr + 1'b1;
                    phase     <= 1'b0;
                end
            end else if (rd_byte && !at_port) begin
                if (!phase) begin
                    lo_hold <= reg_rdata[TW_BW-1:0];
                    last_lo <= reg_rdata[TW_BW-1:0];
                    phase   <= 1'b1;
                end else begin
                    ptr   <= ptr + 1'b1;
                    phase <= 1'b0;
                end
            end
        end
    end

    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                                            // R3
    AST_PORT_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_waddr != TW_LOW_PORT));                         // R7
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_re && reg_we));                                           // R3
endmodule

// File: rtl/twowire_reg_slave.sv
// Two-wire serial slave giving byte-serial access to 16-bit registers.
// Bit engine: address match, acknowledge, receive and transmit shifting.
// Assumes an SCL phase lasts several system clocks; no clock stretching.
// SDA is only pulled low (sda_oe) and is changed only after SCL falls.
module twowire_reg_slave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic             adr0,
    input  logic             adr1,
    output logic             reg_re,
    output logic [TW_AW-1:0] reg_raddr,
    input  logic [TW_DW-1:0] reg_rdata,
    output logic             reg_we,
    output logic [TW_AW-1:0] reg_waddr,
    output logic [TW_DW-1:0] reg_wdata
);
    localparam logic [6:0] BASE7 = TW_BASE_ADDR[7:1];

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    tw_state_t        state;
    logic [TW_BW-1:0] sh, tx, tx_byte;
    logic [3:0]       bits;
    logic             rw, acked;
    logic [6:0]       dev7;
    logic             byte_done, set_ptr, wr_byte, rd_byte;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    tw_word_access u_access (
        .clk(clk), .rst_n(rst_n), .frame_start(start_ev),
        .set_ptr(set_ptr), .wr_byte(wr_byte), .rd_byte(rd_byte),
        .rx_byte(sh), .tx_byte(tx_byte), .reg_rdata(reg_rdata),
        .reg_re(reg_re), .reg_raddr(reg_raddr),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    // Strapped 7-bit device address: adr0 -> address bit 3, adr1 -> bit 5.
    assign dev7 = BASE7 | {2'b00, adr1, 1'b0, adr0, 2'b00};

    // Byte-level events handed to the word access logic.
    always_comb begin
        byte_done = scl_fall && (bits == 4'd8);
        set_ptr   = (state == S_REG) && byte_done;
        wr_byte   = (state == S_WDATA) && byte_done;
        rd_byte   = scl_fall && (((state == S_ACK_A) && rw) ||
                                 ((state == S_RACK) && acked));
    end

    // Protocol state machine, shift registers and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            sh     <= '0;
            tx     <= '0;
            bits   <= '0;
            rw     <= 1'b0;
            acked  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else if (start_ev) begin
            state  <= S_ADDR;
            bits   <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                S_ADDR, S_REG, S_WDATA: begin
                    if (scl_rise) begin
                        sh   <= {sh[TW_BW-2:0], sda_s};
                        bits <= bits + 4'd1;
                    end else if (byte_done) begin
                        bits <= '0;
                        if (state == S_ADDR) begin
                            if (sh[7:1] == dev7) begin
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                                state  <= S_ACK_A;
                            end else begin
                                state  <= S_IDLE;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= (state == S_REG) ? S_ACK_R : S_ACK_W;
                        end
                    end
                end
                S_ACK_A: begin
                    if (scl_fall) begin
                        bits <= '0;
                        if (rw) begin
                            tx     <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            state  <= S_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= S_REG;
                        end
                    end
                end
                S_ACK_R, S_ACK_W: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bits   <= '0;
                        state  <= S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (bits == 4'd7) begin
                            sda_oe <= 1'b0;
                            bits   <= '0;
                            state  <= S_RACK;
                        end else begin
                            tx     <= {tx[TW_BW-2:0], 1'b0};
                            sda_oe <= ~tx[6];
                            bits   <= bits + 4'd1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        acked <= ~sda_s;
                    end else if (scl_fall) begin
                        if (acked) begin
                            tx     <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            bits   <= '0;
                            state  <= S_RDATA;
                        end else begin
                            state  <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);                          // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);                                 // R2
    AST_MATCH_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_ADDR && state == S_ACK_A) |-> sda_oe);       // R1
    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_RACK && state == S_IDLE) |-> !sda_oe);       // R5
endmodule

// File: tb/twowire_reg_slave_test.sv
module twowire_reg_slave_test;
    localparam int HP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1, adr0 = 1'b0, adr1 = 1'b0;
    logic sda_oe, reg_re, reg_we;
    logic [7:0] reg_raddr, reg_waddr;
    logic [15:0] reg_wdata, reg_rdata;
    logic sda_line;
    assign sda_line = m_sda & ~sda_oe;

    logic [15:0] mem [256];
    int wcount = 0, errors = 0, checks = 0, oe_bad = 0;
    logic oe_prev = 1'b0;
    logic [7:0] dev = 8'h90;

    assign reg_rdata = mem[reg_raddr];

    initial for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_waddr] <= reg_wdata;
            wcount <= wcount + 1;
        end
        oe_prev <= sda_oe;
        if (rst_n && (sda_oe != oe_prev) && m_scl) oe_bad <= oe_bad + 1;
    end

    twowire_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .adr0(adr0), .adr1(adr1),
        .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nak);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(HP);
            m_scl = 1'b1; tick(HP);
            m_scl = 1'b0; tick(2);
        end
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP/2);
        nak = sda_line; tick(HP/2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            m_scl = 1'b1; tick(HP/2);
            b[i] = sda_line; tick(HP/2);
            m_scl = 1'b0; tick(2);
        end
        m_sda = nack; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    // Write n data bytes (taken MSB first from d) at pointer ra; naks[k] = ack bit of byte k.
    task automatic wr(input logic [7:0] ra, input logic [31:0] d, input int n,
                      output logic [5:0] naks);
        logic a;
        naks = '0;
        bus_start();
        send_byte(dev & 8'hFE, a); naks[0] = a;
        send_byte(ra, a);          naks[1] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(d[31-8*k -: 8], a); naks[2+k] = a;
        end
        bus_stop();
    endtask

    // Read n bytes starting at pointer ra; last byte answered with no-acknowledge.
    task automatic rd(input logic [7:0] ra, input int n, output logic [31:0] d,
                      output logic [2:0] naks);
        logic a;
        logic [7:0] b;
        d = '0;
        bus_start();
        send_byte(dev & 8'hFE, a); naks[0] = a;
        send_byte(ra, a);          naks[1] = a;
        bus_start();
        send_byte(dev | 8'h01, a); naks[2] = a;
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            d[31-8*k -: 8] = b;
        end
        bus_stop();
    endtask

    // Pointer, then word; mixed, all ones, all zeros, alternating bits.
    localparam logic [23:0] VEC [4] = '{24'h30_1234, 24'h01_FFFF, 24'h7F_0000, 24'hEF_A55A};

    initial begin
        logic [5:0] wn;
        logic [2:0] rn;
        logic [31:0] d;
        logic [7:0] b;
        logic a;
        int wc;

        tick(5);
        check("R9 reset sda_oe", {31'b0, sda_oe}, 32'h0);
        check("R9 reset reg_we", {31'b0, reg_we}, 32'h0);
        check("R9 reset reg_re", {31'b0, reg_re}, 32'h0);
        rst_n = 1'b1;
        tick(5);

        for (int v = 0; v < 4; v++) begin
            wr(VEC[v][23:16], {VEC[v][15:0], 16'h0}, 2, wn);
            check("R1/R3 write acks", {26'b0, wn}, 32'h0);
            check("R3 word stored", {16'b0, mem[VEC[v][23:16]]}, {16'b0, VEC[v][15:0]});
            rd(VEC[v][23:16], 2, d, rn);
            check("R5 read acks", {29'b0, rn}, 32'h0);
            check("R5 word read MSB first", {16'b0, d[31:16]}, {16'b0, VEC[v][15:0]});
        end

        // R2: wrong address ignored
        dev = 8'h98; wc = wcount;
        wr(8'h05, 32'hAABB_0000, 2, wn);
        check("R2 mismatch not acked", {28'b0, wn[3:0]}, 32'hF);
        check("R2 no write on mismatch", wc, wcount);
        check("R2 register untouched", {16'b0, mem[8'h05]}, 32'hDEAD);

        // R1: strap pins select the address
        adr0 = 1'b1; dev = 8'h98;
        wr(8'h40, 32'h1111_0000, 2, wn);
        check("R1 adr0 address acked", {26'b0, wn}, 32'h0);
        check("R1 adr0 write", {16'b0, mem[8'h40]}, 32'h1111);
        adr1 = 1'b1; dev = 8'hB8;
        wr(8'h41, 32'h2222_0000, 2, wn);
        check("R1 both straps acked", {26'b0, wn}, 32'h0);
        check("R1 both straps write", {16'b0, mem[8'h41]}, 32'h2222);
        dev = 8'h90;
        wr(8'h42, 32'h3333_0000, 2, wn);
        check("R1 base address refused with straps high", {31'b0, wn[0]}, 32'h1);
        adr0 = 1'b0; adr1 = 1'b0;

        // R4: auto-increment per word
        wr(8'h10, 32'h0102_0304, 4, wn);
        check("R4 burst acks", {26'b0, wn}, 32'h0);
        check("R4 first word", {16'b0, mem[8'h10]}, 32'h0102);
        check("R4 second word", {16'b0, mem[8'h11]}, 32'h0304);
        rd(8'h10, 4, d, rn);
        check("R4 burst read", d, 32'h0102_0304);

        // R5: no-acknowledge ends the read
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h30, a);
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b1, b);
        check("R5 byte before nack", {24'b0, b}, 32'h12);
        tick(HP);
        check("R5 SDA released after nack", {31'b0, sda_oe}, 32'h0);
        recv_byte(1'b1, b);
        check("R5 silent after nack", {24'b0, b}, 32'hFF);
        bus_stop();

        // R6: start ends a write; lone byte not written
        wc = wcount;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h22, a);
        send_byte(8'h77, a);
        bus_start();
        bus_stop();
        check("R6 start-cut write no strobe", wc, wcount);
        check("R6 register untouched", {16'b0, mem[8'h22]}, 32'hDEAD);
        wr(8'h20, 32'h5A00_0000, 1, wn);
        check("R6 lone byte no strobe", wc, wcount);

        // R7: low-byte port commits staged word
        wr(8'hF0, 32'hC300_0000, 1, wn);
        check("R7 port write acked", {26'b0, wn}, 32'h0);
        check("R7 staged word committed", {16'b0, mem[8'h20]}, 32'h5AC3);
        check("R7 port register not written", {16'b0, mem[8'hF0]}, 32'hDEAD);

        // R8: low-byte port read
        rd(8'h30, 2, d, rn);
        rd(8'hF0, 1, d, rn);
        check("R8 port returns low byte", {24'b0, d[31:24]}, 32'h34);
        rd(8'hEF, 1, d, rn);
        check("R8 upper byte only read", {24'b0, d[31:24]}, 32'hA5);
        rd(8'hF0, 1, d, rn);
        check("R8 port after partial read", {24'b0, d[31:24]}, 32'h5A);

        check("R9 sda_oe moved only with SCL low", oe_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule